// File: doc/BRIEF.md
# Page-Translating MMU with Direct-Indexed Translation Buffer

This block turns virtual addresses of a 24-bit space into 32-bit physical addresses using 4 KB pages. Every virtual page has exactly one slot in a translation buffer, selected by the page number. A lookup that finds its slot filled answers in the same cycle as the request. A lookup that finds its slot empty reads the page's 32-bit mapping from a single-level table in physical memory. It then stores the mapping and answers one cycle later. The table for each quarter of the page space has its own base register and its own enable. Writing a quarter's enable register empties every buffer slot of that quarter.

A requester raises `req_valid` with an address and a read/write flag, and holds them until `rsp_valid` is seen. Each answer is one of three kinds: a translated address, "unmapped" (the request must be left unanswered on the system bus), or a bus error. A byte-wide write port sets the table bases, the quarter enables and the global translation enable. While translation is off, the request address is passed straight through. Only one translation is in flight at a time.

Top module: `pgx_mmu`

## Requirements
- R1: While global translation is disabled, every request is answered in the same cycle with kind OK and `rsp_paddr` equal to the zero-extended request address, without any table read.
- R2: On a buffer hit whose entry has the present flag (mapping bit 0) set and that raises no write fault, the answer is kind OK (`rsp_kind` = 0) with `rsp_paddr` = mapping bits 31:12 followed by request bits 11:0.
- R3: On a miss in an enabled quarter, the block issues two 16-bit reads. The first read takes mapping bits 31:16 from base OR (page bits 9:0 shifted left by 2), and the second takes bits 15:0 from that address plus 2. The block then fills the slot, and later accesses to the page need no reads.
- R4: When translation is enabled and a page misses in a quarter (page bits 11:10) whose enable is clear, the answer is kind unmapped (`rsp_kind` = 1) with no table read.
- R5: A mapping whose present flag (bit 0) is clear yields kind unmapped for reads and for writes.
- R6: A write to a present page whose writable flag (mapping bit 1) is clear yields kind bus error (`rsp_kind` = 2). A read of the same page is translated normally.
- R7: Any write to a quarter's enable register empties all buffer slots of that quarter, and only of that quarter.
- R8: Register map on the byte port: quarter q uses addresses 4q, 4q+1 and 4q+2 for base bits 31:24, 23:16 and 15:8 (base bits 7:0 are zero), and address 4q+3 bit 0 for the enable. Address 0x15 bit 0 is the global translation enable.
- R9: While a table walk is in progress, no answer is given, and a pending memory read holds its address until it is acknowledged.
- R10: After reset, translation and all quarters are disabled, the buffer is empty and no memory read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request, held until answered |
| req_write | input | 1 | Request is a write |
| req_addr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Answer present this cycle |
| rsp_kind | output | 2 | 0 OK, 1 unmapped, 2 bus error |
| rsp_paddr | output | 32 | Physical address (meaningful for OK) |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_ack | input | 1 | Table read completes this cycle |
| mem_rd_data | input | 16 | Table read data |
| io_wr | input | 1 | Configuration byte write strobe |
| io_addr | input | 8 | Configuration register address |
| io_wdata | input | 8 | Configuration write data |

## Verification
The bench builds the block with a 16-bit virtual space and 12-bit pages. This leaves 16 pages, four per quarter, so every slot and every quarter can be swept in full. Each page's mapping is an arithmetic function of the page number, which covers every combination of the present and writable flags. With so few pages, the bench can also check by read counts that a flush of one quarter spares the other three.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int MAP_W      = 32;
  localparam int NUM_QUART  = 4;
  localparam int QSEL_W     = 2;
  localparam int BASE_W     = 24;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_UNMAPPED = 2'd1,
    RSP_BUSERR   = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_HI   = 2'd1,
    WK_LO   = 2'd2,
    WK_FILL = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pgx_rst_sync.sv
module pgx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/pgx_cfg.sv
module pgx_cfg
  import pgx_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                io_wr,
  input  logic [7:0]                          io_addr,
  input  logic [7:0]                          io_wdata,
  output logic                                xlate_en,
  output logic [NUM_QUART-1:0]                quart_en,
  output logic [NUM_QUART-1:0][BASE_W-1:0]    quart_base,
  output logic [NUM_QUART-1:0]                quart_flush
);
  localparam logic [7:0] GLOBAL_REG = 8'h15;
  localparam int         QREG_SPAN  = 4 * NUM_QUART;

  logic                              xen_q, xen_d;
  logic [NUM_QUART-1:0]              qen_q, qen_d;
  logic [NUM_QUART-1:0][BASE_W-1:0]  base_q, base_d;
  logic [NUM_QUART-1:0]              flush_d;
  logic [QSEL_W-1:0]                 sel;

  assign sel = io_addr[QSEL_W+1:2];

  always_comb begin
    xen_d   = xen_q;
    qen_d   = qen_q;
    base_d  = base_q;
    flush_d = '0;
    if (io_wr) begin
      if (io_addr < 8'(QREG_SPAN)) begin
        case (io_addr[1:0])
          2'd0: base_d[sel][23:16] = io_wdata;
          2'd1: base_d[sel][15:8]  = io_wdata;
          2'd2: base_d[sel][7:0]   = io_wdata;
          default: begin
            qen_d[sel]   = io_wdata[0];
            flush_d[sel] = 1'b1;
          end
        endcase
      end else if (io_addr == GLOBAL_REG) begin
        xen_d = io_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xen_q  <= 1'b0;
      qen_q  <= '0;
      base_q <= '0;
    end else if (io_wr) begin
      xen_q  <= xen_d;
      qen_q  <= qen_d;
      base_q <= base_d;
    end
  end

  assign xlate_en    = xen_q;
  assign quart_en    = qen_q;
  assign quart_base  = base_q;
  assign quart_flush = flush_d;
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb
  import pgx_pkg::*;
#(
  parameter int PN_W  = 12,
  parameter int ENT_W = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PN_W-1:0]      lkp_page,
  output logic                 lkp_hit,
  output logic [ENT_W-1:0]     lkp_ent,
  input  logic                 fill_we,
  input  logic [PN_W-1:0]      fill_page,
  input  logic [ENT_W-1:0]     fill_ent,
  input  logic [NUM_QUART-1:0] flush
);
  localparam int ENTRIES = 1 << PN_W;
  localparam int QSZ     = ENTRIES / NUM_QUART;

  logic [ENT_W-1:0]   ent_mem [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_d, set_m, clr_m;

  for (genvar g = 0; g < NUM_QUART; g++) begin : g_quart_clr
    assign clr_m[g*QSZ +: QSZ] = {QSZ{flush[g]}};
  end

  always_comb begin
    set_m = '0;
    if (fill_we) set_m[fill_page] = 1'b1;
    vld_d = (vld_q | set_m) & ~clr_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we) ent_mem[fill_page] <= fill_ent;
  end

  assign lkp_hit = vld_q[lkp_page];
  assign lkp_ent = ent_mem[lkp_page];
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk
  import pgx_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int PN_W   = 12,
  parameter int ENT_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PN_W-1:0]   start_page,
  input  logic [MAP_W-1:0]  start_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_data,
  output logic              busy,
  output logic              mem_rd_valid,
  output logic [MAP_W-1:0]  mem_rd_addr,
  output logic              fill_we,
  output logic [PN_W-1:0]   fill_page,
  output logic [ENT_W-1:0]  fill_ent
);
  walk_st_e           st_q, st_d;
  logic [MAP_W-1:0]   addr_q, addr_d;
  logic [PN_W-1:0]    page_q, page_d;
  logic [ENT_W-1:0]   ent_q, ent_d;
  logic               unused_flag_bits;

  assign unused_flag_bits = ^mem_data[PAGE_W-1:2];

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    page_d = page_q;
    ent_d  = ent_q;
    case (st_q)
      WK_IDLE: if (start) begin
        st_d   = WK_HI;
        addr_d = start_addr;
        page_d = start_page;
      end
      WK_HI: if (mem_ack) begin
        ent_d[ENT_W-1 -: 16] = mem_data;
        st_d = WK_LO;
      end
      WK_LO: if (mem_ack) begin
        ent_d[ENT_W-17:2] = mem_data[15:PAGE_W];
        ent_d[1:0]        = mem_data[1:0];
        st_d = WK_FILL;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (st_q == WK_IDLE) begin
      addr_q <= addr_d;
      page_q <= page_d;
    end
    if (st_q == WK_HI || st_q == WK_LO) ent_q <= ent_d;
  end

  assign busy         = (st_q != WK_IDLE);
  assign mem_rd_valid = (st_q == WK_HI) || (st_q == WK_LO);
  assign mem_rd_addr  = (st_q == WK_LO) ? addr_q + MAP_W'(2) : addr_q;
  assign fill_we      = (st_q == WK_FILL);
  assign fill_page    = page_q;
  assign fill_ent     = ent_q;
endmodule

// File: rtl/pgx_mmu.sv
module pgx_mmu
  import pgx_pkg::*;
#(
  parameter int VA_W   = 24,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [31:0]       rsp_paddr,
  output logic              mem_rd_valid,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [15:0]       mem_rd_data,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata
);
  localparam int PN_W  = VA_W - PAGE_W;
  localparam int IDX_W = PN_W - QSEL_W;
  localparam int ENT_W = MAP_W - PAGE_W + 2;

  logic                              rst_sync_n;
  logic                              xen;
  logic [NUM_QUART-1:0]              qen, qflush;
  logic [NUM_QUART-1:0][BASE_W-1:0]  qbase;
  logic [PN_W-1:0]                   page;
  logic [QSEL_W-1:0]                 qsel;
  logic [IDX_W-1:0]                  idx;
  logic [MAP_W-1:0]                  tbl_addr;
  logic                              hit, walk_busy, walk_go, fill_we;
  logic [ENT_W-1:0]                  hit_ent, fill_ent;
  logic [PN_W-1:0]                   fill_page;
  rsp_kind_e                         kind;

  pgx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pgx_cfg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .xlate_en(xen), .quart_en(qen),
    .quart_base(qbase), .quart_flush(qflush)
  );

  assign page     = req_addr[VA_W-1:PAGE_W];
  assign qsel     = page[PN_W-1 -: QSEL_W];
  assign idx      = page[IDX_W-1:0];
  assign tbl_addr = {qbase[qsel], 8'h00} | (MAP_W'(idx) << 2);

  pgx_tlb #(.PN_W(PN_W), .ENT_W(ENT_W)) u_tlb (
    .clk(clk), .rst_n(rst_sync_n), .lkp_page(page), .lkp_hit(hit),
    .lkp_ent(hit_ent), .fill_we(fill_we), .fill_page(fill_page),
    .fill_ent(fill_ent), .flush(qflush)
  );

  assign walk_go = req_valid && xen && !walk_busy && !hit && qen[qsel];

  pgx_walk #(.PAGE_W(PAGE_W), .PN_W(PN_W), .ENT_W(ENT_W)) u_walk (
    .clk(clk), .rst_n(rst_sync_n), .start(walk_go), .start_page(page),
    .start_addr(tbl_addr), .mem_ack(mem_rd_ack), .mem_data(mem_rd_data),
    .busy(walk_busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .fill_we(fill_we), .fill_page(fill_page), .fill_ent(fill_ent)
  );

  always_comb begin
    rsp_valid = 1'b0;
    kind      = RSP_OK;
    rsp_paddr = MAP_W'(req_addr);
    if (req_valid) begin
      if (!xen) begin
        rsp_valid = 1'b1;
      end else if (!walk_busy) begin
        if (hit) begin
          rsp_valid = 1'b1;
          rsp_paddr = {hit_ent[ENT_W-1:2], req_addr[PAGE_W-1:0]};
          if (!hit_ent[0])                   kind = RSP_UNMAPPED;
          else if (req_write && !hit_ent[1]) kind = RSP_BUSERR;
        end else if (!qen[qsel]) begin
          rsp_valid = 1'b1;
          kind      = RSP_UNMAPPED;
        end
      end
    end
  end

  assign rsp_kind = kind;
endmodule

// File: rtl/pgx_mmu_chk.sv
module pgx_mmu_chk #(
  parameter int VA_W   = 24,
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [VA_W-1:0] req_addr,
  input logic            rsp_valid,
  input logic [1:0]      rsp_kind,
  input logic [31:0]     rsp_paddr,
  input logic            mem_rd_valid,
  input logic            mem_rd_ack,
  input logic [31:0]     mem_rd_addr,
  input logic            xlate_en
);
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlate_en) |-> (rsp_valid && rsp_kind == 2'd0 && rsp_paddr == 32'(req_addr)));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd0) |-> (rsp_paddr[PAGE_W-1:0] == req_addr[PAGE_W-1:0]));

  a_r3_low_half_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ack && !mem_rd_addr[1]) |=>
      (mem_rd_valid && mem_rd_addr == $past(mem_rd_addr) + 32'd2));

  a_r6_buserr_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> req_write);

  a_r9_silent_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !rsp_valid);

  a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r10_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3));
endmodule

bind pgx_mmu pgx_mmu_chk #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .rsp_paddr(rsp_paddr), .mem_rd_valid(mem_rd_valid), .mem_rd_ack(mem_rd_ack),
  .mem_rd_addr(mem_rd_addr), .xlate_en(xen)
);

// File: tb/sim_pgx_mmu.sv
module sim_pgx_mmu;
  localparam int  VA      = 16;
  localparam int  PG      = 12;
  localparam int  NPAGES  = 1 << (VA - PG);
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [VA-1:0] req_addr;
  logic          rsp_valid;
  logic [1:0]    rsp_kind;
  logic [31:0]   rsp_paddr;
  logic          mem_rd_valid, mem_rd_ack;
  logic [31:0]   mem_rd_addr;
  logic [15:0]   mem_rd_data;
  logic          io_wr;
  logic [7:0]    io_addr, io_wdata;

  int tests = 0, fails = 0, rdcnt = 0, logn = 0;
  logic [31:0] rdlog [2];

  always #(CLK_PER/2) clk = ~clk;

  pgx_mmu #(.VA_W(VA), .PAGE_W(PG)) u0 (.*);

  function automatic logic [31:0] exp_map(int p);
    logic [19:0] fr = 20'hA0000 + 20'(p * 19);
    logic pr = (p % 4) != 3;
    logic wr = (p % 3) != 1;
    return {fr, 9'd0, 1'(p & 1), wr, pr};
  endfunction

  function automatic logic [15:0] mem_word(logic [31:0] a);
    int p = int'(a[9:8]) * 4 + int'(a[3:2]);
    logic [31:0] m = exp_map(p);
    return a[1] ? m[15:0] : m[31:16];
  endfunction

  always @(negedge clk) begin
    if (mem_rd_ack) mem_rd_ack = 1'b0;
    else if (mem_rd_valid) begin
      mem_rd_ack  = 1'b1;
      mem_rd_data = mem_word(mem_rd_addr);
      if (logn < 2) rdlog[logn] = mem_rd_addr;
      logn++;
      rdcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic xlate(input logic [VA-1:0] a, input bit w,
                       output logic [1:0] k, output logic [31:0] pa,
                       output int rd, output int n);
    int r0;
    @(negedge clk);
    r0 = rdcnt; logn = 0;
    req_valid = 1'b1; req_addr = a; req_write = w;
    #1;
    n = 0;
    while (!rsp_valid && n < 60) begin
      @(negedge clk); #1; n++;
    end
    k = rsp_kind; pa = rsp_paddr; rd = rdcnt - r0;
    req_valid = 1'b0;
  endtask

  function automatic logic [1:0] exp_kind(int p, bit w);
    logic [31:0] m = exp_map(p);
    if (!m[0]) return 2'd1;
    if (w && !m[1]) return 2'd2;
    return 2'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] k; logic [31:0] pa; int rd, n;
    logic [VA-1:0] a; logic [PG-1:0] off;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    mem_rd_ack = 1'b0; mem_rd_data = '0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!rsp_valid && !mem_rd_valid, "R10 idle after reset", {rsp_valid, mem_rd_valid}, 0);

    // R1 / R10: translation off after reset
    for (int i = 0; i < 64; i++) begin
      a = VA'(i * 16'h0407 + 3);
      xlate(a, i[0], k, pa, rd, n);
      chk(k == 2'd0 && pa == 32'(a) && rd == 0 && n == 0, "R1 passthrough", pa, 32'(a));
    end

    // R4 / R10 / R8: global on, all quarters off
    io_write(8'h15, 8'h01);
    for (int p = 0; p < NPAGES; p++) begin
      xlate(VA'(p << PG), 1'b0, k, pa, rd, n);
      chk(k == 2'd1 && rd == 0, "R4 quarter disabled", {k, 4'(rd)}, 16);
    end

    // R8: bases q<<8, enable all quarters
    for (int q = 0; q < 4; q++) begin
      io_write(8'(4*q),   8'h00);
      io_write(8'(4*q+1), 8'h00);
      io_write(8'(4*q+2), 8'(q));
      io_write(8'(4*q+3), 8'h01);
    end

    // R2 R3 R5 R6: first access walks, second hits
    for (int p = 0; p < NPAGES; p++) begin
      off = PG'(p * 12'h1F3 + 5);
      a = {4'(p), off};
      xlate(a, 1'b0, k, pa, rd, n);
      chk(rd == 2, "R3 two reads on miss", rd, 2);
      chk(rdlog[0] == 32'((p/4) << 8 | (p%4) << 2) && rdlog[1] == rdlog[0] + 2,
          "R3 table addresses", rdlog[0], 32'((p/4) << 8 | (p%4) << 2));
      chk(n >= 4, "R9 no answer during walk", n, 4);
      chk(k == exp_kind(p, 1'b0), "R5 read kind", k, exp_kind(p, 1'b0));
      if (k == 2'd0)
        chk(pa == {exp_map(p)[31:12], off}, "R2 translated address", pa, {exp_map(p)[31:12], off});
      off = (p % 2 == 1) ? 12'hFFF : 12'h000;
      a = {4'(p), off};
      xlate(a, 1'b1, k, pa, rd, n);
      chk(rd == 0 && n == 0, "R3 hit needs no read", rd, 0);
      chk(k == exp_kind(p, 1'b1), "R6 write kind", k, exp_kind(p, 1'b1));
      if (k == 2'd0)
        chk(pa == {exp_map(p)[31:12], off}, "R2 write address", pa, {exp_map(p)[31:12], off});
    end

    // R7: rewrite quarter 1 enable
    io_write(8'h07, 8'h01);
    for (int p = 0; p < 8; p++) begin
      xlate(VA'(p << PG), 1'b0, k, pa, rd, n);
      chk(rd == ((p >= 4) ? 2 : 0), "R7 flush only own quarter", rd, (p >= 4) ? 2 : 0);
    end

    // R4 R7: disable quarter 2
    io_write(8'h0B, 8'h00);
    for (int p = 8; p < 12; p++) begin
      xlate(VA'(p << PG), 1'b0, k, pa, rd, n);
      chk(k == 2'd1 && rd == 0, "R4 disabled quarter after flush", k, 1);
    end

    // R8: global enable toggle keeps buffer contents
    io_write(8'h15, 8'h00);
    xlate(16'h3ABC, 1'b1, k, pa, rd, n);
    chk(k == 2'd0 && pa == 32'h3ABC && n == 0, "R8 global off passthrough", pa, 32'h3ABC);
    io_write(8'h15, 8'h01);
    xlate(16'hC123, 1'b0, k, pa, rd, n);
    chk(rd == 0 && k == 2'd0 && pa == {exp_map(12)[31:12], 12'h123}, "R8 global on hit kept",
        pa, {exp_map(12)[31:12], 12'h123});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule